// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

The block is a 32-bit processor core that completes one instruction in every clock cycle. It supports five instructions: register add, register subtract, add-immediate, load word and store word. Each cycle the core puts its program counter on an instruction-memory address port and takes back the instruction word in the same cycle. It decodes the word and reads two operands from a 32-entry register file. It forms either an arithmetic result or a byte address of base plus sign-extended offset. The result, or the loaded word, is written back at the next rising clock edge.

Both memories sit outside the core and return read data combinationally. Memory is word-wide. Addresses are byte addresses, so word k sits at byte address 4k and the memory index is the address with its two low bits dropped. Bytes inside a word are ordered big-endian. Only whole words move, so no byte lanes are needed. If a load or store gives an address that is not word-aligned, the core sets a sticky flag and the access has no effect. An opcode or function code the core does not recognise is executed as a no-operation.

Top module: `mc_core`

## Requirements
- R1: During and immediately after synchronous active-low reset, the instruction address is 0, the misalignment flag is 0 and every register reads 0.
- R2: The instruction address advances by exactly 4 on every clock edge out of reset; the instruction fetched is the memory word at index address[31:2].
- R3: Opcode 0 with function 32 writes rs + rt into rd, modulo 2^32, with no trap on overflow.
- R4: Opcode 0 with function 34 writes rs − rt into rd, modulo 2^32.
- R5: Opcode 8 writes rs plus the sign-extended bits [15:0] into rt.
- R6: Opcode 35 reads the data word at byte address rs + sext(imm), memory index address[31:2], and writes it into rt.
- R7: Opcode 43 writes the value of rt to the data word at rs + sext(imm). The data write enable is high only for such a store.
- R8: Register 0 always reads 0, and writes aimed at it are discarded.
- R9: Any other opcode, or opcode 0 with any function other than 32 or 34, changes no register and no memory word.
- R10: A load or store whose address has low bits other than 00 sets the misalignment flag, which then stays set until reset. Such an access writes neither memory nor a register.
- R11: Offsets are two's complement in the range −32768 to +32767, so a negative offset addresses below the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_rdata | input | 32 | Data word at dmem_addr, combinational |
| dmem_wdata | output | 32 | Word to be stored |
| dmem_we | output | 1 | Store this cycle, applied at the rising edge |
| misalign | output | 1 | Sticky misaligned-access flag |

## Verification
The register file is hidden, so a wrong register value stays invisible until a later store or address computation uses that register. The program therefore stores each register it has computed a few cycles after computing it. A reference model compares the fetch address, the store enable, the store address and data, the load address and the flag on every cycle. That exposes a bad program counter or a bad decode in the cycle where it happens. A bad register or memory write shows up at the first store that depends on it, and the final memory image is compared word by word.

// File: rtl/mc_pkg.sv
// Shared encodings and control bundle for the single-cycle core.
package mc_pkg;
    localparam logic [5:0] OP_REG  = 6'd0;
    localparam logic [5:0] OP_ADDI = 6'd8;
    localparam logic [5:0] OP_LW   = 6'd35;
    localparam logic [5:0] OP_SW   = 6'd43;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_SUB  = 6'd34;

    typedef enum logic {ALU_ADD = 1'b0, ALU_SUB = 1'b1} alu_op_e;

    typedef struct packed {
        logic    reg_we;   // instruction writes a register
        logic    use_imm;  // second operand is the extended immediate
        logic    dst_rt;   // destination taken from bits [20:16]
        logic    mem_rd;   // load
        logic    mem_wr;   // store
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/mc_decode.sv
// Instruction decoder: splits the fixed 32-bit word into fields and produces
// the control bundle. Assumes only the five supported encodings matter;
// anything else yields an all-inactive bundle (a no-operation).
module mc_decode
    import mc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic [31:0]     instr,
    output ctrl_t           ctrl,
    output logic [RAW-1:0]  rs,
    output logic [RAW-1:0]  rt,
    output logic [RAW-1:0]  rd,
    output logic [XLEN-1:0] imm_ext
);
    localparam int IMMW = 16;

    logic [5:0] opcode;
    logic [5:0] funct;

    assign opcode  = instr[31:26];
    assign funct   = instr[5:0];
    assign rs      = instr[25:21];
    assign rt      = instr[20:16];
    assign rd      = instr[15:11];
    assign imm_ext = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};

    // Map opcode/function to control; unknown combinations stay inactive.
    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OP_REG: begin
                if (funct == FN_ADD) begin
                    ctrl.reg_we = 1'b1;
                end else if (funct == FN_SUB) begin
                    ctrl.reg_we = 1'b1;
                    ctrl.alu_op = ALU_SUB;
                end
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.dst_rt  = 1'b1;
            end
            OP_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.dst_rt  = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/mc_regfile.sv
// Register file: DEPTH words of XLEN bits, two combinational read ports and
// one write port clocked on the rising edge. Entry 0 is never written, so it
// stays at the zero it receives in reset.
module mc_regfile #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] regs [DEPTH];

    // Clear on reset; otherwise accept a write to any entry except 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    // R8: entry 0 holds zero whatever the write port is offered
    a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);
    // R8: a write aimed at entry 0 leaves the read value at zero
    a_r8_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0 && raddr_a == '0) |-> rdata_a == '0);
endmodule

// File: rtl/mc_alu.sv
// Adder/subtractor: wraps modulo 2^XLEN and signals no overflow.
module mc_alu
    import mc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    // Select sum or difference.
    always_comb begin
        y = (op == ALU_SUB) ? (a - b) : (a + b);
    end

    // R4: adding the subtrahend back recovers the minuend (modulo 2^XLEN)
    always_comb begin
        if (op == ALU_SUB) a_r4_sub_inverse: assert (XLEN'(y + b) == a);
    end
endmodule

// File: rtl/mc_core.sv
// Single-cycle core top: program counter, fetch, decode, register file,
// ALU, data access and write-back. Assumes both memories answer reads
// combinationally and apply writes at the rising edge.
module mc_core
    import mc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NREGS  = 32,
    localparam int RAW   = $clog2(NREGS),
    localparam int STEP  = XLEN / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    output logic            misalign
);
    localparam int LOWB = $clog2(STEP);

    ctrl_t           ctrl;
    logic [RAW-1:0]  rs, rt, rd;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opa, opb, alu_b, alu_y;
    logic [XLEN-1:0] pc;
    logic            bad_align;
    logic            rf_we;
    logic [RAW-1:0]  rf_waddr;
    logic [XLEN-1:0] rf_wdata;

    // Program counter: zero in reset, one word forward every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc + XLEN'(STEP);
    end
    assign imem_addr = pc;

    mc_decode #(.XLEN(XLEN), .RAW(RAW)) u_dec (
        .instr   (imem_rdata),
        .ctrl    (ctrl),
        .rs      (rs),
        .rt      (rt),
        .rd      (rd),
        .imm_ext (imm_ext)
    );

    mc_regfile #(.XLEN(XLEN), .DEPTH(NREGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (rs),
        .raddr_b (rt),
        .rdata_a (opa),
        .rdata_b (opb)
    );

    assign alu_b = ctrl.use_imm ? imm_ext : opb;

    mc_alu #(.XLEN(XLEN)) u_alu (
        .op (ctrl.alu_op),
        .a  (opa),
        .b  (alu_b),
        .y  (alu_y)
    );

    // Data side: the ALU sum is the byte address; misaligned accesses are cancelled.
    assign bad_align  = (ctrl.mem_rd || ctrl.mem_wr) && (alu_y[LOWB-1:0] != '0);
    assign dmem_addr  = alu_y;
    assign dmem_wdata = opb;
    assign dmem_we    = ctrl.mem_wr && !bad_align;

    // Write-back: loaded word or ALU result, suppressed on a cancelled load.
    assign rf_we    = ctrl.reg_we && !bad_align;
    assign rf_waddr = ctrl.dst_rt ? rt : rd;
    assign rf_wdata = ctrl.mem_rd ? dmem_rdata : alu_y;

    // Sticky flag: set by the first misaligned access, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         misalign <= 1'b0;
        else if (bad_align) misalign <= 1'b1;
    end

    // R2: fetch address steps by one word per cycle
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> imem_addr == $past(imem_addr) + XLEN'(STEP));
    // R10: the flag never falls outside reset
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> misalign);
    // R10: no store leaves the core with an unaligned address
    a_r10_aligned_store: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> dmem_addr[LOWB-1:0] == '0);
    // R9: an unrecognised opcode touches neither memory nor registers
    a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[31:26] != OP_REG && imem_rdata[31:26] != OP_ADDI &&
         imem_rdata[31:26] != OP_LW  && imem_rdata[31:26] != OP_SW)
        |-> (!dmem_we && !rf_we));
    // R7: the write enable appears only under the store opcode
    a_r7_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> imem_rdata[31:26] == OP_SW);
endmodule

// File: tb/mc_core_tb.sv
// Bench: preloads a program and data, steps a behavioural reference model
// alongside the core and compares the ports on every cycle.
module mc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, dmem_wdata;
    logic        dmem_we, misalign;

    logic [31:0] im [64];
    logic [31:0] dm [64];
    logic [31:0] rdm [64];
    logic [31:0] rrf [32];
    logic [31:0] rpc;
    logic        rmis;
    int          nchk = 0, nerr = 0;

    always #2 clk = ~clk;

    mc_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .misalign   (misalign)
    );

    assign imem_rdata = im[imem_addr[7:2]];
    assign dmem_rdata = dm[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] enc_r(int s, int t, int d, int fn);
        return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int s, int t, int imm);
        return {6'(op), 5'(s), 5'(t), 16'(imm)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference step: compares this cycle's port values, then executes.
    task automatic ref_cycle();
        logic [31:0] ins, sx, ea, va, vb;
        logic [5:0]  op, fn;
        int          s, t, d;
        ins = im[rpc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        s = int'(ins[25:21]); t = int'(ins[20:16]); d = int'(ins[15:11]);
        sx = {{16{ins[15]}}, ins[15:0]};
        va = rrf[s]; vb = rrf[t];
        ea = va + sx;
        chk("R2 fetch address", imem_addr, rpc);
        chk("R10 flag", {31'd0, misalign}, {31'd0, rmis});
        chk("R7 write enable", {31'd0, dmem_we},
            {31'd0, (op == 6'd43 && ea[1:0] == 2'b00)});
        if (op == 6'd43 || op == 6'd35) chk("R6/R11 data address", dmem_addr, ea);
        if (op == 6'd43 && ea[1:0] == 2'b00) chk("R7 store data", dmem_wdata, vb);
        case (op)
            6'd0: begin
                if (fn == 6'd32) rrf[d] = va + vb;
                else if (fn == 6'd34) rrf[d] = va - vb;
            end
            6'd8: rrf[t] = ea;
            6'd35: if (ea[1:0] == 2'b00) rrf[t] = rdm[ea[7:2]]; else rmis = 1'b1;
            6'd43: if (ea[1:0] == 2'b00) rdm[ea[7:2]] = vb; else rmis = 1'b1;
            default: ;
        endcase
        rrf[0] = '0;
        rpc = rpc + 4;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #8000;
        nchk++; nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin im[i] = '0; dm[i] = '0; end
        for (int i = 0; i < 32; i++) rrf[i] = '0;
        dm[2] = 32'h0000_3333; dm[5] = 32'h0000_1111; dm[6] = 32'd5000;
        dm[7] = 32'h0000_2222; dm[10] = 32'h7FFF_FFFF;
        im[0]  = enc_i(8, 0, 19, 16);          // base = 16
        im[1]  = enc_i(8, 0, 18, 1000);        // b = 1000
        im[2]  = enc_i(35, 19, 8, 8);          // load A[2]
        im[3]  = enc_r(8, 18, 8, 34);          // A[2] - b
        im[4]  = enc_i(43, 19, 8, 32);         // store A[8]
        im[5]  = enc_r(8, 18, 9, 32);
        im[6]  = enc_i(43, 19, 9, 0);
        im[7]  = enc_i(8, 0, 0, 55);           // write to register 0
        im[8]  = enc_i(43, 19, 0, 4);
        im[9]  = enc_i(63, 19, 8, 4);          // unknown opcode
        im[10] = enc_r(8, 9, 10, 42);          // unknown function
        im[11] = enc_i(43, 19, 10, 12);
        im[12] = enc_i(43, 19, 8, -4);         // negative offset store
        im[13] = enc_i(35, 19, 12, -8);        // negative offset load
        im[14] = enc_i(43, 19, 12, 40);
        im[15] = enc_i(43, 19, 8, 2);          // misaligned store
        im[16] = enc_i(35, 19, 8, 1);          // misaligned load
        im[17] = enc_i(43, 19, 8, 36);
        im[18] = enc_i(35, 19, 13, 24);
        im[19] = enc_r(13, 13, 14, 32);        // overflowing add
        im[20] = enc_i(43, 19, 14, 44);
        im[21] = enc_r(0, 18, 15, 34);         // 0 - 1000
        im[22] = enc_i(43, 19, 15, 28);
        for (int i = 0; i < 64; i++) rdm[i] = dm[i];
        rpc = '0; rmis = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset address", imem_addr, 32'd0);
        chk("R1 reset flag", {31'd0, misalign}, 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 30; c++) begin
            ref_cycle();
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 address after reset", imem_addr, 32'd0);
        chk("R1 flag after reset", {31'd0, misalign}, 32'd0);

        chk("R4 R6 R7 A[8] = A[2] - b", dm[12], 32'd4000);
        chk("R3 add result stored", dm[4], 32'd5000);
        chk("R8 register 0 stored as zero", dm[5], 32'd0);
        chk("R9 unknown left rd at zero", dm[7], 32'd0);
        chk("R11 negative offset store", dm[3], 32'd4000);
        chk("R11 negative offset load", dm[14], 32'h0000_3333);
        chk("R10 misaligned load kept register", dm[13], 32'd4000);
        chk("R3 wrap without trap", dm[15], 32'hFFFF_FFFE);
        chk("R4 wrap on subtract", dm[11], 32'hFFFF_FC18);
        chk("R5 addi base via store address", dm[12], rdm[12]);
        for (int i = 0; i < 64; i++) chk("R7 final memory image", dm[i], rdm[i]);
        finish_run();
    end
endmodule